// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes command words that a 16-bit processor bus writes into an embedded flash region, and it drives a small array model behind it. A command is one or two bus writes to even addresses. Only the low byte of a command word is decoded. Two-cycle commands carry either the program data or a shared confirm byte (D0h) in their second write. Reads are steered by the current read mode, which stays in force until another command is accepted. In array mode a read returns the stored word. In status mode it returns a status byte that reports ready/busy, the last lock query and two sticky error flags.

The array is organised as `2**BLK_BITS` blocks of `2**WSEL_W` words. Blocks `0..ALL_LAST` form the bulk-erasable region. Block `ALL_LAST+1` (block 13 by default) is protected: bulk erase never touches it, and only a single-block erase clears it. A per-block lock bit refuses programming and erasing unless the `lockProtDis` input is high. Program and erase run over several cycles. While they run, `ready` is low, command writes are dropped and every read returns the status byte.

A byte address is `{block, wordInBlock, 1'b0}`. With the default parameters it is 7 bits wide: block in bits 6..3 and word in bits 2..1.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array read mode, `ready` is 1, both error flags are 0, and every array word reads FFFFh.
- R2: Only bits 7..0 of a command word are decoded, so bits 15..8 have no effect. A write to an odd address is ignored entirely.
- R3: Command FFh selects array mode. Every following read returns the addressed word until another command is accepted.
- R4: Command 70h selects status mode. A status read returns 00h in bits 15..8 and the following status byte: bit 7 = ready, bit 6 = lock state from the last lock query (1 = locked), bit 5 = erase error, bit 4 = program error, bits 3..0 = 0.
- R5: Command 50h clears both error flags, which otherwise stay set. It does not change the read mode.
- R6: Command 40h followed by a data write to the same even address stores that data word. If the second write goes to a different address, the program error is set and nothing is stored.
- R7: Commands 20h (block erase), A7h (erase all), 77h (lock block) and 71h (query lock) need a second write carrying D0h. For 20h, 77h and 71h that write must also go to the top even address of the block (word bits all 1). Otherwise the sequence is dropped. A failed 20h or A7h sets the erase error; a failed 77h or 71h sets the program error.
- R8: The second write of any two-cycle command, whether it succeeds or fails, switches the read mode to status.
- R9: While a program or erase runs, `ready` is 0, command writes are ignored, and every read returns the status byte with bit 7 = 0.
- R10: Erase-all sets to FFFFh every word of blocks `0..ALL_LAST` whose block is unlocked (or whose lock is overridden). The protected block and all blocks above it keep their data.
- R11: Block erase sets every word of the addressed block to FFFFh, and this includes the protected block.
- R12: Command 77h locks a block, and 71h loads that block's lock state into status bit 6. A program to a locked block sets the program error and a block erase of a locked block sets the erase error, in both cases without changing data. When `lockProtDis` is 1 neither is refused.
- R13: An unrecognised first-cycle code is ignored and leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | BLK_BITS+WSEL_W+1 | Byte address, shared by reads and writes |
| busWrData | input | 16 | Write data: a command code in bits 7..0, or the program data |
| lockProtDis | input | 1 | 1 = lock bits are not enforced |
| busRdData | output | 16 | Read data, valid the cycle after `busRdEn` |
| busRdValid | output | 1 | High the cycle after a read request |
| ready | output | 1 | 0 while a program or erase runs |
| progErrFlag | output | 1 | Sticky program error |
| eraseErrFlag | output | 1 | Sticky erase error |

## Verification
The scoreboard goes after the places where a command sequence can go wrong.

- **Confirm handling.** A wrong confirm byte, or a confirm aimed at a non-top address, must abort with the matching error. A design that fails here would erase the block anyway, or raise the wrong flag.
- **Program address.** A program whose data write moves to another address must not store anything. A design that keys only on the second write would store the data.
- **Writes while busy.** A FFh written while a program is still running must not leave status mode. A design that accepts it would switch to array reads early.
- **Erase-all coverage.** After an erase-all, the protected block, a locked block and a block above the bulk range must still hold data. A walk that runs one block too far, or ignores locks, would wipe them.
- **Lock behaviour.** Lock queries must report the right block, and the lock override must let a program through to a locked block.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] OP_PROGRAM     = 8'h40;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h20;
  localparam logic [7:0] OP_ERASE_ALL   = 8'hA7;
  localparam logic [7:0] OP_LOCK_SET    = 8'h77;
  localparam logic [7:0] OP_LOCK_QUERY  = 8'h71;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG_DATA, SEQ_CONFIRM} seqState_t;
  typedef enum logic [1:0] {ENG_IDLE, ENG_PROG, ENG_ERASE} engMode_t;

  // Strobes from the sequencer to the array datapath, valid for one cycle
  typedef struct packed {
    logic progGo;
    logic blkEraseGo;
    logic allEraseGo;
    logic lockSet;
    logic lockQuery;
    logic progErrSet;
    logic eraseErrSet;
    logic errClr;
  } seqStrobe_t;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        code,
  input  logic              busy,
  output seqStrobe_t        strobe,
  output logic              statusMode,
  output logic              seqIdle
);

  seqState_t         state;
  logic [7:0]        pendCode;
  logic [ADDR_W-1:0] pendAddr;

  logic accept, atBlockTop, confirmOk, pendIsErase;

  assign accept      = wrEn && !busy && !addr[0];
  assign atBlockTop  = &addr[WSEL_W:1];
  assign confirmOk   = (code == OP_CONFIRM) && ((pendCode == OP_ERASE_ALL) || atBlockTop);
  assign pendIsErase = (pendCode == OP_BLOCK_ERASE) || (pendCode == OP_ERASE_ALL);
  assign seqIdle     = (state == SEQ_IDLE);

  always_comb begin
    strobe = '0;
    if (accept) begin
      case (state)
        SEQ_IDLE: strobe.errClr = (code == OP_CLEAR_ERR);
        SEQ_PROG_DATA: begin
          if (addr == pendAddr) strobe.progGo = 1'b1;
          else                  strobe.progErrSet = 1'b1;
        end
        SEQ_CONFIRM: begin
          if (confirmOk) begin
            strobe.blkEraseGo = (pendCode == OP_BLOCK_ERASE);
            strobe.allEraseGo = (pendCode == OP_ERASE_ALL);
            strobe.lockSet    = (pendCode == OP_LOCK_SET);
            strobe.lockQuery  = (pendCode == OP_LOCK_QUERY);
          end else if (pendIsErase) begin
            strobe.eraseErrSet = 1'b1;
          end else begin
            strobe.progErrSet = 1'b1;
          end
        end
        default: strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      statusMode <= 1'b0;
      pendCode   <= '0;
      pendAddr   <= '0;
    end else if (accept) begin
      if (state == SEQ_IDLE) begin
        case (code)
          OP_READ_ARRAY:  statusMode <= 1'b0;
          OP_READ_STATUS: statusMode <= 1'b1;
          OP_PROGRAM: begin
            state    <= SEQ_PROG_DATA;
            pendAddr <= addr;
          end
          OP_BLOCK_ERASE, OP_ERASE_ALL, OP_LOCK_SET, OP_LOCK_QUERY: begin
            state    <= SEQ_CONFIRM;
            pendCode <= code;
          end
          default: ;
        endcase
      end else begin
        state      <= SEQ_IDLE;
        statusMode <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array
  import flash_cmd_pkg::*;
#(
  parameter int BLK_BITS = 4,
  parameter int WSEL_W   = 2,
  parameter int ALL_LAST = 12,
  parameter int PROG_CYC = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobe,
  input  logic [BLK_BITS+WSEL_W-1:0] wordAddr,
  input  logic [15:0]                wrData,
  input  logic                       rdEn,
  input  logic                       statusMode,
  input  logic                       lockProtDis,
  output logic [15:0]                rdData,
  output logic                       rdValid,
  output logic                       busy,
  output logic                       progErr,
  output logic                       eraseErr
);

  localparam int WORD_W  = BLK_BITS + WSEL_W;
  localparam int NWORDS  = 1 << WORD_W;
  localparam int NBLK    = 1 << BLK_BITS;
  localparam int ALL_END = (ALL_LAST + 1) * (1 << WSEL_W) - 1;
  localparam int CNT_W   = $clog2(PROG_CYC + 1);

  logic [15:0]        mem [NWORDS];
  logic [NBLK-1:0]    lockBits;
  logic               lockStat;
  engMode_t           engMode;
  logic [CNT_W-1:0]   engCnt;
  logic [WORD_W-1:0]  engAddr, engEnd, progAddr;
  logic [15:0]        progData;
  logic               engChk;

  logic [BLK_BITS-1:0] tgtBlk, walkBlk;
  logic                tgtLocked, walkWrite;
  logic [7:0]          statusByte;

  assign tgtBlk     = wordAddr[WORD_W-1:WSEL_W];
  assign tgtLocked  = lockBits[tgtBlk] && !lockProtDis;
  assign walkBlk    = engAddr[WORD_W-1:WSEL_W];
  assign walkWrite  = !engChk || !lockBits[walkBlk] || lockProtDis;
  assign busy       = (engMode != ENG_IDLE);
  assign statusByte = {!busy, lockStat, eraseErr, progErr, 4'b0000};

  // Lock bits and status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBits <= '0;
      lockStat <= 1'b0;
      progErr  <= 1'b0;
      eraseErr <= 1'b0;
    end else begin
      if (strobe.errClr) begin
        progErr  <= 1'b0;
        eraseErr <= 1'b0;
      end
      if (strobe.progErrSet || (strobe.progGo && tgtLocked))      progErr  <= 1'b1;
      if (strobe.eraseErrSet || (strobe.blkEraseGo && tgtLocked)) eraseErr <= 1'b1;
      if (strobe.lockSet)   lockBits[tgtBlk] <= 1'b1;
      if (strobe.lockQuery) lockStat <= lockBits[tgtBlk];
    end
  end

  // Program / erase engine and array storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= 16'hFFFF;
      engMode  <= ENG_IDLE;
      engCnt   <= '0;
      engAddr  <= '0;
      engEnd   <= '0;
      engChk   <= 1'b0;
      progAddr <= '0;
      progData <= '0;
    end else begin
      case (engMode)
        ENG_IDLE: begin
          if (strobe.progGo && !tgtLocked) begin
            engMode  <= ENG_PROG;
            engCnt   <= CNT_W'(PROG_CYC - 1);
            progAddr <= wordAddr;
            progData <= wrData;
          end else if (strobe.blkEraseGo && !tgtLocked) begin
            engMode <= ENG_ERASE;
            engAddr <= {tgtBlk, {WSEL_W{1'b0}}};
            engEnd  <= {tgtBlk, {WSEL_W{1'b1}}};
            engChk  <= 1'b0;
          end else if (strobe.allEraseGo) begin
            engMode <= ENG_ERASE;
            engAddr <= '0;
            engEnd  <= WORD_W'(ALL_END);
            engChk  <= 1'b1;
          end
        end
        ENG_PROG: begin
          if (engCnt == '0) begin
            mem[progAddr] <= progData;
            engMode       <= ENG_IDLE;
          end else begin
            engCnt <= engCnt - 1'b1;
          end
        end
        ENG_ERASE: begin
          if (walkWrite) mem[engAddr] <= 16'hFFFF;
          if (engAddr == engEnd) engMode <= ENG_IDLE;
          else                   engAddr <= engAddr + 1'b1;
        end
        default: engMode <= ENG_IDLE;
      endcase
    end
  end

  // Read steering: status while busy or in status mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= (statusMode || busy) ? {8'h00, statusByte} : mem[wordAddr];
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int BLK_BITS = 4,
  parameter int WSEL_W   = 2,
  parameter int ALL_LAST = 12,
  parameter int PROG_CYC = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [BLK_BITS+WSEL_W:0]   busAddr,
  input  logic [15:0]                busWrData,
  input  logic                       lockProtDis,
  output logic [15:0]                busRdData,
  output logic                       busRdValid,
  output logic                       ready,
  output logic                       progErrFlag,
  output logic                       eraseErrFlag
);

  seqStrobe_t seqStrobe;
  logic       statusMode, busy, seqIdle;

  flash_cmd_seq #(.ADDR_W(BLK_BITS + WSEL_W + 1), .WSEL_W(WSEL_W)) i_seq (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr),
    .code(busWrData[7:0]), .busy(busy),
    .strobe(seqStrobe), .statusMode(statusMode), .seqIdle(seqIdle)
  );

  flash_cmd_array #(.BLK_BITS(BLK_BITS), .WSEL_W(WSEL_W),
                    .ALL_LAST(ALL_LAST), .PROG_CYC(PROG_CYC)) i_array (
    .clk(clk), .rstN(rstN), .strobe(seqStrobe),
    .wordAddr(busAddr[BLK_BITS+WSEL_W:1]), .wrData(busWrData),
    .rdEn(busRdEn), .statusMode(statusMode), .lockProtDis(lockProtDis),
    .rdData(busRdData), .rdValid(busRdValid), .busy(busy),
    .progErr(progErrFlag), .eraseErr(eraseErrFlag)
  );

  assign ready = !busy;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        wrCode,
  input logic [15:0]       busRdData,
  input logic              ready,
  input logic              progErrFlag,
  input logic              eraseErrFlag,
  input logic              seqIdle
);

  logic clrCmd;
  assign clrCmd = seqIdle && busWrEn && ready && !busAddr[0] && (wrCode == 8'h50);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ready && !progErrFlag && !eraseErrFlag));

  assert_status_layout_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !ready) |=> (busRdData[15:7] == 9'd0 && busRdData[3:0] == 4'd0));

  assert_clear_errors_R5: assert property (@(posedge clk) disable iff (!rstN)
    clrCmd |=> (!progErrFlag && !eraseErrFlag));

  assert_prog_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (progErrFlag && !clrCmd) |=> progErrFlag);

  assert_busy_drops_writes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && busWrEn) |=> ($stable(progErrFlag) && $stable(eraseErrFlag)));

  assert_busy_needs_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(busWrEn));

endmodule

bind flash_cmd_ctrl flash_cmd_checker #(.ADDR_W(BLK_BITS + WSEL_W + 1)) i_checker (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
  .wrCode(busWrData[7:0]), .busRdData(busRdData), .ready(ready),
  .progErrFlag(progErrFlag), .eraseErrFlag(eraseErrFlag), .seqIdle(seqIdle)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0, lockProtDis = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        busRdValid, ready, progErrFlag, eraseErrFlag;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .lockProtDis(lockProtDis),
    .busRdData(busRdData), .busRdValid(busRdValid), .ready(ready),
    .progErrFlag(progErrFlag), .eraseErrFlag(eraseErrFlag)
  );

  function automatic logic [6:0] ba(input int b, input int w);
    logic [3:0] bb;
    logic [1:0] ww;
    bb = b[3:0];
    ww = w[1:0];
    return {bb, ww, 1'b0};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one bus write per cycle
  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // Driver: a read request, its expected data goes to the scoreboard
  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string tag);
    busRdEn = 1'b1; busAddr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
  endtask

  task automatic prog(input int b, input int w, input logic [15:0] d);
    wr(ba(b, w), 16'h0040);
    wr(ba(b, w), d);
    waitReady();
  endtask

  // Monitor: compares each returned read against the scoreboard
  always @(negedge clk) begin
    if (busRdValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard: unexpected read data %h expected none", busRdData);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal(t, busRdData, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkVal("R1 ready", {15'd0, ready}, 16'd1);
    checkVal("R1 flags", {14'd0, progErrFlag, eraseErrFlag}, 16'd0);
    rd(ba(0, 0), 16'hFFFF, "R1 erased array");

    // R6 program, R9 busy behaviour
    wr(ba(0, 2), 16'h0040);
    wr(ba(0, 2), 16'h1234);
    checkVal("R9 busy", {15'd0, ready}, 16'd0);
    rd(ba(5, 0), 16'h0000, "R9 read while busy");
    wr(ba(0, 0), 16'h00FF);                 // dropped: still busy
    waitReady();
    rd(ba(0, 0), 16'h0080, "R9 write during busy ignored / R8 status mode");
    wr(ba(0, 0), 16'h00FF);
    rd(ba(0, 2), 16'h1234, "R6 programmed word");
    rd(ba(0, 3), 16'hFFFF, "R3 consecutive read");
    rd(ba(0, 2), 16'h1234, "R3 array mode persists");

    // R2 high byte ignored, odd address ignored; R13 unknown code
    wr(ba(0, 0), 16'hAB70);
    rd(ba(0, 2), 16'h0080, "R2 high byte ignored, R4 status layout");
    wr(7'h01, 16'h00FF);
    rd(ba(0, 2), 16'h0080, "R2 odd address write ignored");
    wr(ba(0, 0), 16'h0011);
    rd(ba(0, 2), 16'h0080, "R13 unknown code ignored");

    // R6 address mismatch
    wr(ba(1, 0), 16'h0040);
    wr(ba(1, 1), 16'h5555);
    checkVal("R6 mismatch sets prog error", {15'd0, progErrFlag}, 16'd1);
    rd(ba(1, 0), 16'h0090, "R6 status after mismatch");
    wr(ba(0, 0), 16'h00FF);
    rd(ba(1, 0), 16'hFFFF, "R6 nothing stored at first address");
    rd(ba(1, 1), 16'hFFFF, "R6 nothing stored at second address");

    // R5 clear status keeps mode
    wr(ba(0, 0), 16'h0050);
    checkVal("R5 flags cleared", {14'd0, progErrFlag, eraseErrFlag}, 16'd0);
    rd(ba(0, 2), 16'h1234, "R5 mode unchanged by clear");

    // R7 confirm errors
    wr(ba(0, 3), 16'h0020);
    wr(ba(0, 3), 16'h00D1);
    rd(ba(0, 0), 16'h00A0, "R7 wrong confirm on block erase");
    wr(ba(0, 0), 16'h0050);
    wr(ba(0, 3), 16'h0020);
    wr(ba(0, 1), 16'h00D0);
    rd(ba(0, 0), 16'h00A0, "R7 confirm not at block top");
    wr(ba(0, 0), 16'h00FF);
    rd(ba(0, 2), 16'h1234, "R7 failed erase left data");
    wr(ba(0, 0), 16'h0050);
    wr(ba(3, 3), 16'h0077);
    wr(ba(3, 3), 16'h00D5);
    rd(ba(0, 0), 16'h0090, "R7 wrong confirm on lock sets prog error");
    wr(ba(0, 0), 16'h0050);

    // R11 block erase, R8 status mode afterwards
    wr(ba(0, 3), 16'h0020);
    wr(ba(0, 3), 16'h00D0);
    waitReady();
    rd(ba(0, 0), 16'h0080, "R8 status after block erase");
    wr(ba(0, 0), 16'h00FF);
    rd(ba(0, 2), 16'hFFFF, "R11 block erased");

    // R12 locking
    prog(2, 1, 16'hBEEF);
    wr(ba(2, 3), 16'h0077);
    wr(ba(2, 3), 16'h00D0);
    wr(ba(2, 3), 16'h0071);
    wr(ba(2, 3), 16'h00D0);
    rd(ba(0, 0), 16'h00C0, "R12 query locked block");
    wr(ba(3, 3), 16'h0071);
    wr(ba(3, 3), 16'h00D0);
    rd(ba(0, 0), 16'h0080, "R12 query unlocked block");
    wr(ba(2, 0), 16'h0040);
    wr(ba(2, 0), 16'h1111);
    checkVal("R12 locked program refused (ready)", {15'd0, ready}, 16'd1);
    rd(ba(0, 0), 16'h0090, "R12 locked program error");
    wr(ba(0, 0), 16'h0050);
    wr(ba(2, 3), 16'h0020);
    wr(ba(2, 3), 16'h00D0);
    rd(ba(0, 0), 16'h00A0, "R12 locked erase error");
    wr(ba(0, 0), 16'h0050);
    wr(ba(0, 0), 16'h00FF);
    rd(ba(2, 1), 16'hBEEF, "R12 locked block kept data");
    rd(ba(2, 0), 16'hFFFF, "R12 refused program stored nothing");

    // R10 erase-all
    prog(5, 0, 16'h5A5A);
    prog(12, 3, 16'h0C0C);
    prog(13, 0, 16'hD00D);
    prog(14, 2, 16'hE0E0);
    wr(ba(0, 0), 16'h00A7);
    wr(ba(7, 1), 16'h00D0);
    waitReady();
    checkVal("R10 no error after erase-all", {14'd0, progErrFlag, eraseErrFlag}, 16'd0);
    wr(ba(0, 0), 16'h00FF);
    rd(ba(5, 0), 16'hFFFF, "R10 block 5 erased");
    rd(ba(12, 3), 16'hFFFF, "R10 last bulk block erased");
    rd(ba(13, 0), 16'hD00D, "R10 protected block kept");
    rd(ba(14, 2), 16'hE0E0, "R10 block above range kept");
    rd(ba(2, 1), 16'hBEEF, "R10 locked block kept");

    // R11 protected block by block erase
    wr(ba(13, 3), 16'h0020);
    wr(ba(13, 3), 16'h00D0);
    waitReady();
    wr(ba(0, 0), 16'h00FF);
    rd(ba(13, 0), 16'hFFFF, "R11 protected block erased by block erase");

    // R12 lock override
    lockProtDis = 1'b1;
    prog(2, 0, 16'h2222);
    checkVal("R12 override no error", {15'd0, progErrFlag}, 16'd0);
    wr(ba(0, 0), 16'h00FF);
    rd(ba(2, 0), 16'h2222, "R12 override program stored");
    lockProtDis = 1'b0;

    repeat (4) @(negedge clk);
    checkVal("scoreboard drained", 16'(expQ.size()), 16'd0);
    summary();
    $finish;
  end

endmodule